// File: doc/BRIEF.md
# Cascadable Display-Row Input Latch

This block is the digital input stage of one column-driver slice in a chain of identical slices. It stays idle until a one-cycle start pulse arrives on its enable input. From the next pixel-clock edge onward, each rising edge captures six 8-bit pixel codes from a 48-bit bus into a row of per-column code registers. Each 24-bit half of the bus can arrive bit-inverted to cut bus switching, and the block restores it before storing.

Slices are chained by wiring the enable output of one to the enable input of the next. The enable output rises a few edges before the row is full, which gives the next slice time to sample it. After the last group is stored the slice stops capturing by itself and stays in standby until the line strobe. The line strobe clears the enable outputs and re-arms the slice. Row registers keep their codes until they are overwritten.

A direction input picks which of the two enable pins is the input and which is the output. It also sets whether the row fills from its first cell upward or from its last cell downward. A mode input selects a 384-cell or a 402-cell row. In the 402-cell mode, a parity input marks a slice that takes the even-ordered fetches.

Top module: `row_capture_latch`

## Requirements
- R1: While capturing, each rising clock edge stores six codes at once. Bus lane j occupies data_in[8j+7:8j], and lanes 0..5 go to six consecutive fill positions in lane order.
- R2: The start pulse is taken from the selected enable input on a rising edge, and that edge counts as edge 1. Edge 2 stores the first group, and edge 1 stores nothing.
- R3: The selected enable output goes high right after edge 63 in 384-cell mode, or after edge 66 in 402-cell mode. It stays high until the line strobe.
- R4: Capture ends by itself at edge 66 (384-cell mode) or edge 69 (402-cell mode). Once it has ended, bus data changes no cell, and a new start pulse is ignored until the line strobe.
- R5: pol_lo=1 inverts data_in[23:0] before storage, and pol_hi=1 inverts data_in[47:24]. Each flag qualifies the data on the same edge. A flag at 0 leaves its half unchanged.
- R6: With dir_fwd=1, en_a_in is the input and en_b_out is the output, and fill position p writes cell p. With dir_fwd=0, en_b_in is the input and en_a_out is the output, and position p writes cell L-1-p, where L is the row length. The enable output on the input side stays low. A pulse on the output-side enable input starts nothing.
- R7: line_strobe=1 on an edge clears both enable outputs and returns the slice to idle. The stored codes are kept.
- R8: wide_mode=0 gives a 384-cell row (L=384), and cells 384..401 are never written. wide_mode=1 gives L=402.
- R9: With wide_mode=1 and even_slice=1, the two three-lane halves swap: fill lane j takes bus lane (j+3) mod 6. When wide_mode=0, even_slice has no effect.
- R10: After synchronous active-low reset, every cell is 0, both enable outputs are low and the slice is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_strobe | input | 1 | Line-start strobe; clears enable outputs and re-arms |
| dir_fwd | input | 1 | 1: start on en_a, fill upward; 0: start on en_b, fill downward |
| wide_mode | input | 1 | 0: 384-cell row; 1: 402-cell row |
| even_slice | input | 1 | In 402-cell mode, marks the even-fetch slice |
| pol_lo | input | 1 | Lower bus half (lanes 0..2) arrives inverted |
| pol_hi | input | 1 | Upper bus half (lanes 3..5) arrives inverted |
| data_in | input | 48 | Six 8-bit pixel codes |
| en_a_in | input | 1 | Enable input when dir_fwd=1 |
| en_b_in | input | 1 | Enable input when dir_fwd=0 |
| en_a_out | output | 1 | Enable output when dir_fwd=0 |
| en_b_out | output | 1 | Enable output when dir_fwd=1 |
| row_o | output | 3216 | Stored codes, cell i at bits [8i+7:8i] |

## Verification
Three kinds of internal fault reach the ports:
- A wrong capture counter moves the handoff edge on the enable output, and the error is visible within one edge of the expected edge 63 or 66.
- A wrong write pointer or a wrong fill direction puts codes into the wrong cells of row_o on the edge that writes them.
- A capture state that fails to halt, or that ignores a strobe, lets data after the row or a stray start pulse overwrite cells. This shows up in row_o on the next edge.

Every run drives data on the edges before and after the capture window, so an off-by-one start or end leaves a wrong code in row_o.

// File: rtl/row_capture_latch.sv
`timescale 1ns/1ps
module row_capture_latch #(
  parameter int LANES        = 6,
  parameter int CODE_W       = 8,
  parameter int MAX_OUTS     = 402,
  parameter int BASE_OUTS    = 384,
  parameter int BASE_HANDOFF = 63,
  parameter int BASE_HALT    = 66,
  parameter int WIDE_HANDOFF = 66,
  parameter int WIDE_HALT    = 69
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         line_strobe,
  input  logic                         dir_fwd,
  input  logic                         wide_mode,
  input  logic                         even_slice,
  input  logic                         pol_lo,
  input  logic                         pol_hi,
  input  logic [LANES*CODE_W-1:0]      data_in,
  input  logic                         en_a_in,
  input  logic                         en_b_in,
  output logic                         en_a_out,
  output logic                         en_b_out,
  output logic [MAX_OUTS*CODE_W-1:0]   row_o
);
  localparam int BUS_W = LANES * CODE_W;
  localparam int HALF  = BUS_W / 2;
  localparam int PW    = $clog2(MAX_OUTS + LANES + 1);
  localparam int CW    = $clog2(WIDE_HALT + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_t;

  st_t               st;
  logic [PW-1:0]     ptr;
  logic [CW-1:0]     cnt;
  logic              en_q;
  logic [CODE_W-1:0] cells [MAX_OUTS];

  logic [PW-1:0]     row_len;
  logic [CW-1:0]     handoff_at, halt_at;
  logic              start_seen;
  logic [BUS_W-1:0]  clean;
  logic [CODE_W-1:0] lane   [LANES];
  logic [PW-1:0]     wr_idx [LANES];
  logic              wr_ok  [LANES];

  assign row_len    = wide_mode ? PW'(MAX_OUTS) : PW'(BASE_OUTS);
  assign handoff_at = wide_mode ? CW'(WIDE_HANDOFF - 1) : CW'(BASE_HANDOFF - 1);
  assign halt_at    = wide_mode ? CW'(WIDE_HALT - 1) : CW'(BASE_HALT - 1);
  assign start_seen = dir_fwd ? en_a_in : en_b_in;
  assign clean      = data_in ^ {{HALF{pol_hi}}, {HALF{pol_lo}}};
  assign en_a_out   = en_q & ~dir_fwd;
  assign en_b_out   = en_q & dir_fwd;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane[j] = (wide_mode && even_slice)
                   ? clean[((j + LANES/2) % LANES)*CODE_W +: CODE_W]
                   : clean[j*CODE_W +: CODE_W];
  end

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      wr_ok[j]  = (ptr + PW'(j)) < row_len;
      wr_idx[j] = dir_fwd ? ptr + PW'(j) : row_len - PW'(1) - ptr - PW'(j);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      ptr  <= '0;
      cnt  <= '0;
      en_q <= 1'b0;
      for (int i = 0; i < MAX_OUTS; i++) cells[i] <= '0;
    end else if (line_strobe) begin
      st   <= ST_IDLE;
      ptr  <= '0;
      cnt  <= '0;
      en_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start_seen) begin
          st  <= ST_RUN;
          cnt <= CW'(1);
          ptr <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + CW'(1);
          if (cnt == handoff_at) en_q <= 1'b1;
          if (cnt == halt_at) st <= ST_DONE;
          for (int j = 0; j < LANES; j++)
            if (wr_ok[j]) cells[wr_idx[j]] <= lane[j];
          ptr <= (ptr + PW'(LANES) >= row_len) ? row_len : ptr + PW'(LANES);
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < MAX_OUTS; i++) begin : g_row
    assign row_o[i*CODE_W +: CODE_W] = cells[i];
  end

  // R6
  en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_a_out, en_b_out}));

  // R7
  strobe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_strobe |=> (!en_a_out && !en_b_out && st == ST_IDLE));

  // R2
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start_seen && !line_strobe) |=> (st == ST_RUN && cnt == CW'(1)));

  // R3
  handoff_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> ($past(cnt) == $past(handoff_at)));

  // R4
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && cnt == halt_at && !line_strobe) |=> st == ST_DONE);

  // R8
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(MAX_OUTS));
endmodule

// File: tb/row_capture_latch_bench.sv
`timescale 1ns/1ps
module row_capture_latch_bench;
  localparam int N = 402;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, line_strobe, dir_fwd, wide_mode, even_slice, pol_lo, pol_hi;
  logic [47:0] data_in;
  logic en_a_in, en_b_in, en_a_out, en_b_out;
  logic [N*8-1:0] row_o;

  row_capture_latch u_row_capture_latch (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .dir_fwd(dir_fwd),
    .wide_mode(wide_mode), .even_slice(even_slice), .pol_lo(pol_lo), .pol_hi(pol_hi),
    .data_in(data_in), .en_a_in(en_a_in), .en_b_in(en_b_in),
    .en_a_out(en_a_out), .en_b_out(en_b_out), .row_o(row_o));

  logic [7:0] exp_row [N];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  function automatic logic [7:0] code_of(int seed, int k, int j);
    return 8'(seed * 13 + k * 7 + j * 37 + j * k);
  endfunction

  task automatic check_bit(string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, expv);
    end
  endtask

  task automatic check_int(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic check_row(string tag);
    int bad = 0;
    int first = 0;
    for (int i = 0; i < N; i++)
      if (row_o[i*8 +: 8] !== exp_row[i]) begin
        if (bad == 0) first = i;
        bad++;
      end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: %0d cells differ, cell %0d got %0h expected %0h",
               tag, bad, first, row_o[first*8 +: 8], exp_row[first]);
    end
  endtask

  task automatic strobe();
    @(negedge clk);
    line_strobe = 1'b1; en_a_in = 1'b0; en_b_in = 1'b0;
    @(negedge clk);
    line_strobe = 1'b0;
  endtask

  task automatic drive_bus(int seed, int k, bit polmix);
    logic lo, hi;
    lo = polmix ? logic'(k % 2) : 1'b0;
    hi = polmix ? logic'((k / 2) % 2) : 1'b0;
    pol_lo = lo; pol_hi = hi;
    for (int j = 0; j < 6; j++)
      data_in[j*8 +: 8] = ((j < 3) ? lo : hi) ? ~code_of(seed, k, j) : code_of(seed, k, j);
  endtask

  // Covers R1, R2, R3, R5, R6, R8, R9 depending on arguments
  task automatic run_row(string tag, bit fwd, bit wide, bit even, bit polmix, int seed);
    int len  = wide ? 402 : 384;
    int hand = wide ? 66 : 63;
    int halt = wide ? 69 : 66;
    int rise = 0;
    bit wrong = 0;
    strobe();
    dir_fwd = fwd; wide_mode = wide; even_slice = even;
    pol_lo = 1'b0; pol_hi = 1'b0; data_in = '1;
    if (fwd) en_a_in = 1'b1; else en_b_in = 1'b1;
    @(posedge clk);
    for (int k = 2; k <= halt + 4; k++) begin
      @(negedge clk);
      en_a_in = 1'b0; en_b_in = 1'b0;
      drive_bus(seed, k, polmix);
      if (k - 2 < len / 6)
        for (int j = 0; j < 6; j++) begin
          int src = (wide && even) ? (j + 3) % 6 : j;
          int pos = (k - 2) * 6 + j;
          exp_row[fwd ? pos : len - 1 - pos] = code_of(seed, k, src);
        end
      @(posedge clk); #1;
      if ((fwd ? en_b_out : en_a_out) && rise == 0) rise = k;
      if (fwd ? en_a_out : en_b_out) wrong = 1;
    end
    check_int({tag, " R3 handoff edge"}, rise, hand);
    check_bit({tag, " R6 input-side enable stays low"}, wrong, 1'b0);
    check_row({tag, " R1/R2/R6 row contents"});
  endtask

  // R4: stray start after halt, no strobe
  task automatic stray_start();
    @(negedge clk);
    if (dir_fwd) en_a_in = 1'b1; else en_b_in = 1'b1;
    drive_bus(77, 1, 0);
    for (int k = 0; k < 75; k++) begin
      @(negedge clk);
      en_a_in = 1'b0; en_b_in = 1'b0;
      drive_bus(77, k + 2, 0);
    end
    @(posedge clk); #1;
    check_row("R4 standby ignores data and start");
    check_bit("R3 enable output held until strobe", en_b_out, 1'b1);
  endtask

  // R7: strobe clears enable outputs, keeps row
  task automatic strobe_clear();
    strobe();
    #1;
    check_bit("R7 en_b_out cleared", en_b_out, 1'b0);
    check_bit("R7 en_a_out cleared", en_a_out, 1'b0);
    check_row("R7 row kept after strobe");
  endtask

  // R6: start on output-side pin does nothing
  task automatic wrong_pin();
    strobe();
    dir_fwd = 1'b1; wide_mode = 1'b0; even_slice = 1'b0;
    en_b_in = 1'b1;
    drive_bus(91, 1, 0);
    for (int k = 0; k < 75; k++) begin
      @(negedge clk);
      en_b_in = 1'b0;
      drive_bus(91, k + 2, 0);
    end
    @(posedge clk); #1;
    check_row("R6 output-side start ignored");
    check_bit("R6 no handoff without start", en_b_out, 1'b0);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) exp_row[i] = 8'h00;
    rst_n = 1'b0; line_strobe = 1'b0; dir_fwd = 1'b1; wide_mode = 1'b0;
    even_slice = 1'b0; pol_lo = 1'b0; pol_hi = 1'b0; data_in = '1;
    en_a_in = 1'b0; en_b_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_row("R10 reset row zero");
    check_bit("R10 reset en_a_out", en_a_out, 1'b0);
    check_bit("R10 reset en_b_out", en_b_out, 1'b0);

    run_row("fwd narrow", 1, 0, 0, 0, 1);
    stray_start();
    strobe_clear();
    run_row("rev narrow R5 pol", 0, 0, 0, 1, 2);
    run_row("fwd wide R8 R5", 1, 1, 0, 1, 3);
    run_row("rev wide even R9", 0, 1, 1, 0, 4);
    run_row("fwd narrow even ignored R9 R8", 1, 0, 1, 1, 5);
    wrong_pin();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule